// File: doc/BRIEF.md
# Decode-Stage Branch Direction Predictor

This block looks at a group of instructions in decode and finds the lowest-numbered slot that holds a branch. It predicts that branch's direction and compares the prediction with the direction that fetch already assumed. When the two differ, it sends a one-cycle redirect to fetch. The redirect carries the branch target when the new prediction is taken. It carries the fall-through address when the new prediction is not taken.

An earlier decoder supplies a two-bit branch class per slot, and the direction source is chosen from that class:
- Unconditional branches are always predicted taken.
- Count-register branches are predicted from the count value that is supplied with the group.
- Branches that test only a condition-register bit read a table of 512 two-bit saturating counters. The table is indexed by the branch's word address.

The execution stage writes each resolved condition-bit branch back into the table.

Top module: `brdir_top`

## Requirements
- R1: After reset `redir_valid` is 0. Every table counter starts in the weak not-taken state (01).
- R2: The branch used is the lowest slot whose class is not none (00). Slots above it have no effect on the redirect.
- R3: A class 01 (unconditional) branch is predicted taken. It redirects to its target only when `fetch_guess_taken` is 0.
- R4: A class 10 (count) branch with `slot_zero_form` bit 0 is predicted taken when `ctr_value - 1` (modulo 2^CW) is nonzero.
- R5: A class 10 branch with `slot_zero_form` bit 1 is predicted taken when `ctr_value - 1` is zero.
- R6: A class 11 (condition-bit) branch is predicted from bit 1 of the counter at index `(dec_pc + slot)[8:0]`. Addresses that agree in those 9 bits share an entry.
- R7: When `upd_valid` is 1, the counter at `upd_pc[8:0]` moves one step. The encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. A taken outcome increments the counter and a not-taken outcome decrements it, saturating at 11 and 00.
- R8: A redirect is raised only when the prediction differs from `fetch_guess_taken`. It appears in the cycle after the decode cycle and lasts one cycle. `redir_addr` is the slot target if the prediction is taken, and `dec_pc + slot + 1` if it is not.
- R9: When a lookup and an update hit the same entry in the same cycle, the lookup sees the value from before the update.
- R10: When `dec_valid` is 0, or no slot holds a branch, there is no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode group present this cycle |
| dec_pc | input | AW | Word address of slot 0 |
| slot_kind | input | 2*NS | Branch class per slot, slot 0 in the low bits |
| slot_zero_form | input | NS | Count-form selector per slot |
| slot_target | input | AW*NS | Target word address per slot |
| fetch_guess_taken | input | 1 | Direction fetch assumed for the first branch |
| ctr_value | input | CW | Current count register value |
| upd_valid | input | 1 | Resolved condition-bit branch this cycle |
| upd_pc | input | AW | Word address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| redir_valid | output | 1 | One-cycle redirect request |
| redir_taken | output | 1 | Direction of the redirect |
| redir_addr | output | AW | Address to fetch from |

## Verification
A counter that steps wrongly, saturates wrongly or is reset wrongly shows up at the next condition-bit lookup of that entry. The bench makes that lookup with the fetch guess chosen so that both outcomes of the lookup are visible, one cycle after decode. A wrong slot choice or a wrong count evaluation shows as a redirect that is missing or extra, or as a wrong address, in the cycle after the group. A forwarding error between update and lookup on the same entry shows in the redirect of the colliding decode. The old value is then confirmed by a later lookup of that entry.

// File: rtl/brdir_pkg.sv
package brdir_pkg;

    typedef enum logic [1:0] {
        BK_NONE   = 2'd0,
        BK_ALWAYS = 2'd1,
        BK_COUNT  = 2'd2,
        BK_FLAG   = 2'd3
    } br_kind_e;

    typedef enum logic [1:0] {
        CS_STRONG_NT = 2'd0,
        CS_WEAK_NT   = 2'd1,
        CS_WEAK_T    = 2'd2,
        CS_STRONG_T  = 2'd3
    } ctr_state_e;

    function automatic logic [1:0] sat_step(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        nxt = cur;
        if (taken && cur != 2'd3)
            nxt = cur + 2'd1;
        else if (!taken && cur != 2'd0)
            nxt = cur - 2'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/brdir_first_sel.sv
module brdir_first_sel
    import brdir_pkg::*;
#(
    parameter int AW = 16,
    parameter int NS = 4,
    localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic [2*NS-1:0]  kinds,
    input  logic [NS-1:0]    zero_forms,
    input  logic [AW*NS-1:0] targets,
    output logic             hit,
    output logic [SW-1:0]    slot,
    output br_kind_e         kind,
    output logic             zero_form,
    output logic [AW-1:0]    target
);

    logic [1:0]    kind_a   [NS];
    logic [AW-1:0] target_a [NS];

    for (genvar g = 0; g < NS; g++) begin : g_unpack
        assign kind_a[g]   = kinds[2*g +: 2];
        assign target_a[g] = targets[AW*g +: AW];
    end

    always_comb begin
        hit       = 1'b0;
        slot      = '0;
        kind      = BK_NONE;
        zero_form = 1'b0;
        target    = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (kind_a[i] != 2'd0) begin
                hit       = 1'b1;
                slot      = SW'(i);
                kind      = br_kind_e'(kind_a[i]);
                zero_form = zero_forms[i];
                target    = target_a[i];
            end
        end
    end

endmodule

// File: rtl/brdir_ctr_eval.sv
module brdir_ctr_eval #(
    parameter int CW = 8
) (
    input  logic [CW-1:0] ctr_value,
    input  logic          zero_form,
    output logic          taken
);

    logic [CW-1:0] after_dec;
    logic          is_zero;

    always_comb begin
        after_dec = ctr_value - CW'(1);
        is_zero   = (after_dec == '0);
        taken     = zero_form ? is_zero : !is_zero;
    end

endmodule

// File: rtl/brdir_bht.sv
module brdir_bht
    import brdir_pkg::*;
#(
    parameter int ENTRIES = 512,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_taken,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_taken
);

    logic [1:0] cnt_q [ENTRIES];
    logic [1:0] cnt_d [ENTRIES];

    // Lookup reads the registered array, so a same-cycle write is not seen.
    assign rd_taken = cnt_q[rd_idx][1];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++)
            cnt_d[i] = cnt_q[i];
        if (wr_en)
            cnt_d[wr_idx] = sat_step(cnt_q[wr_idx], wr_taken);
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n)
                cnt_q[i] <= CS_WEAK_NT;
            else
                cnt_q[i] <= cnt_d[i];
        end
    end

endmodule

// File: rtl/brdir_top.sv
module brdir_top
    import brdir_pkg::*;
#(
    parameter int AW      = 16,
    parameter int NS      = 4,
    parameter int CW      = 8,
    parameter int ENTRIES = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [AW-1:0]    dec_pc,
    input  logic [2*NS-1:0]  slot_kind,
    input  logic [NS-1:0]    slot_zero_form,
    input  logic [AW*NS-1:0] slot_target,
    input  logic             fetch_guess_taken,
    input  logic [CW-1:0]    ctr_value,
    input  logic             upd_valid,
    input  logic [AW-1:0]    upd_pc,
    input  logic             upd_taken,
    output logic             redir_valid,
    output logic             redir_taken,
    output logic [AW-1:0]    redir_addr
);

    localparam int IW = $clog2(ENTRIES);
    localparam int SW = (NS > 1) ? $clog2(NS) : 1;

    typedef struct packed {
        logic          valid;
        logic          taken;
        logic [AW-1:0] addr;
    } redir_t;

    redir_t r_d, r_q;

    logic          sel_hit;
    logic [SW-1:0] sel_slot;
    br_kind_e      sel_kind;
    logic          sel_zero;
    logic [AW-1:0] sel_target;
    logic [AW-1:0] br_pc;
    logic [AW-1:0] fall_pc;
    logic          ctr_taken;
    logic          tbl_taken;
    logic          pred_taken;
    logic          unused_upd_hi;

    assign unused_upd_hi = ^upd_pc[AW-1:IW];

    brdir_first_sel #(.AW(AW), .NS(NS)) sel_i (
        .kinds      (slot_kind),
        .zero_forms (slot_zero_form),
        .targets    (slot_target),
        .hit        (sel_hit),
        .slot       (sel_slot),
        .kind       (sel_kind),
        .zero_form  (sel_zero),
        .target     (sel_target)
    );

    brdir_ctr_eval #(.CW(CW)) ctr_i (
        .ctr_value (ctr_value),
        .zero_form (sel_zero),
        .taken     (ctr_taken)
    );

    assign br_pc   = dec_pc + AW'(sel_slot);
    assign fall_pc = br_pc + AW'(1);

    brdir_bht #(.ENTRIES(ENTRIES)) bht_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (br_pc[IW-1:0]),
        .rd_taken (tbl_taken),
        .wr_en    (upd_valid),
        .wr_idx   (upd_pc[IW-1:0]),
        .wr_taken (upd_taken)
    );

    always_comb begin
        unique case (sel_kind)
            BK_ALWAYS: pred_taken = 1'b1;
            BK_COUNT:  pred_taken = ctr_taken;
            BK_FLAG:   pred_taken = tbl_taken;
            default:   pred_taken = 1'b0;
        endcase

        r_d.valid = dec_valid && sel_hit && (pred_taken != fetch_guess_taken);
        r_d.taken = pred_taken;
        r_d.addr  = pred_taken ? sel_target : fall_pc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign redir_valid = r_q.valid;
    assign redir_taken = r_q.taken;
    assign redir_addr  = r_q.addr;

endmodule

// File: rtl/brdir_chk.sv
module brdir_chk #(
    parameter int AW = 16,
    parameter int NS = 4,
    parameter int CW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dec_valid,
    input logic [2*NS-1:0]  slot_kind,
    input logic [NS-1:0]    slot_zero_form,
    input logic [AW*NS-1:0] slot_target,
    input logic             fetch_guess_taken,
    input logic [CW-1:0]    ctr_value,
    input logic             redir_valid,
    input logic             redir_taken,
    input logic [AW-1:0]    redir_addr
);

    p_no_redirect_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> $past(dec_valid));

    p_no_branch_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && slot_kind == '0) |=> !redir_valid);

    p_disagree_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (redir_taken != $past(fetch_guess_taken)));

    p_uncond_redirect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && slot_kind[1:0] == 2'd1)
            |=> (redir_valid == !$past(fetch_guess_taken)));

    p_uncond_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && slot_kind[1:0] == 2'd1 && !fetch_guess_taken)
            |=> (redir_addr == $past(slot_target[AW-1:0]) && redir_taken));

    p_count_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && slot_kind[1:0] == 2'd2 && !slot_zero_form[0] && ctr_value == CW'(1))
            |=> (redir_valid == $past(fetch_guess_taken)));

    p_count_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && slot_kind[1:0] == 2'd2 && slot_zero_form[0] && ctr_value == CW'(1))
            |=> (redir_valid == !$past(fetch_guess_taken)));

endmodule

bind brdir_top brdir_chk #(.AW(AW), .NS(NS), .CW(CW)) chk_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .dec_valid         (dec_valid),
    .slot_kind         (slot_kind),
    .slot_zero_form    (slot_zero_form),
    .slot_target       (slot_target),
    .fetch_guess_taken (fetch_guess_taken),
    .ctr_value         (ctr_value),
    .redir_valid       (redir_valid),
    .redir_taken       (redir_taken),
    .redir_addr        (redir_addr)
);

// File: tb/brdir_top_tb_top.sv
module brdir_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int NS = 4;
    localparam int CW = 8;

    localparam logic [1:0] K_NO = 2'd0;
    localparam logic [1:0] K_AL = 2'd1;
    localparam logic [1:0] K_CT = 2'd2;
    localparam logic [1:0] K_FL = 2'd3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             dec_valid = 1'b0;
    logic [AW-1:0]    dec_pc = '0;
    logic [2*NS-1:0]  slot_kind = '0;
    logic [NS-1:0]    slot_zero_form = '0;
    logic [AW*NS-1:0] slot_target = '0;
    logic             fetch_guess_taken = 1'b0;
    logic [CW-1:0]    ctr_value = '0;
    logic             upd_valid = 1'b0;
    logic [AW-1:0]    upd_pc = '0;
    logic             upd_taken = 1'b0;
    logic             redir_valid;
    logic             redir_taken;
    logic [AW-1:0]    redir_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brdir_top #(.AW(AW), .NS(NS), .CW(CW)) dut_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .dec_valid         (dec_valid),
        .dec_pc            (dec_pc),
        .slot_kind         (slot_kind),
        .slot_zero_form    (slot_zero_form),
        .slot_target       (slot_target),
        .fetch_guess_taken (fetch_guess_taken),
        .ctr_value         (ctr_value),
        .upd_valid         (upd_valid),
        .upd_pc            (upd_pc),
        .upd_taken         (upd_taken),
        .redir_valid       (redir_valid),
        .redir_taken       (redir_taken),
        .redir_addr        (redir_addr)
    );

    task automatic expect_redir(input string req, input logic ev, input logic et,
                                input logic [AW-1:0] ea);
        n_checks++;
        if (redir_valid !== ev || (ev && (redir_taken !== et || redir_addr !== ea))) begin
            n_fail++;
            $display("FAIL %s: actual v=%0b t=%0b a=%h expected v=%0b t=%0b a=%h",
                     req, redir_valid, redir_taken, redir_addr, ev, et, ea);
        end
    endtask

    // Drive one decode group (optionally with a same-cycle update) and wait past the edge.
    task automatic decode(input logic [AW-1:0] pc, input logic [2*NS-1:0] kinds,
                          input logic [NS-1:0] zf, input logic [AW*NS-1:0] tg,
                          input logic guess, input logic [CW-1:0] ctr,
                          input logic vld, input logic uv, input logic [AW-1:0] up,
                          input logic ut);
        @(negedge clk);
        dec_valid = vld; dec_pc = pc; slot_kind = kinds; slot_zero_form = zf;
        slot_target = tg; fetch_guess_taken = guess; ctr_value = ctr;
        upd_valid = uv; upd_pc = up; upd_taken = ut;
        @(posedge clk);
        #1;
        dec_valid = 1'b0; upd_valid = 1'b0; slot_kind = '0;
    endtask

    task automatic update(input logic [AW-1:0] pc, input logic tk);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = tk;
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
    endtask

    task automatic flag0(input logic [AW-1:0] pc, input logic guess);
        decode(pc, {K_NO, K_NO, K_NO, K_FL}, '0, {48'h0, 16'h0900}, guess, '0,
               1'b1, 1'b0, '0, 1'b0);
    endtask

    task automatic t_reset;
        expect_redir("R1 idle after reset", 1'b0, 1'b0, '0);
        flag0(16'h0010, 1'b1);
        expect_redir("R1 R6 fresh entry weak not-taken", 1'b1, 1'b0, 16'h0011);
    endtask

    task automatic t_uncond;
        decode(16'h0300, {K_NO, K_NO, K_NO, K_AL}, '0, {48'h0, 16'h0AB0}, 1'b0, '0,
               1'b1, 1'b0, '0, 1'b0);
        expect_redir("R3 unconditional guessed not-taken", 1'b1, 1'b1, 16'h0AB0);
        decode(16'h0300, {K_NO, K_NO, K_NO, K_AL}, '0, {48'h0, 16'h0AB0}, 1'b1, '0,
               1'b1, 1'b0, '0, 1'b0);
        expect_redir("R3 R8 unconditional guessed taken", 1'b0, 1'b0, '0);
    endtask

    task automatic t_first;
        decode(16'h0100, {K_AL, K_AL, K_NO, K_NO}, '0,
               {16'h0600, 16'h0500, 16'h0, 16'h0}, 1'b0, '0, 1'b1, 1'b0, '0, 1'b0);
        expect_redir("R2 lowest branch slot 2", 1'b1, 1'b1, 16'h0500);
        decode(16'h0100, {K_AL, K_NO, K_FL, K_NO}, '0,
               {16'h0600, 16'h0, 16'h0700, 16'h0}, 1'b1, '0, 1'b1, 1'b0, '0, 1'b0);
        expect_redir("R2 R8 slot 1 fall-through", 1'b1, 1'b0, 16'h0102);
    endtask

    task automatic t_count;
        decode(16'h0200, {K_NO, K_NO, K_NO, K_CT}, 4'b0000, {48'h0, 16'h0700}, 1'b0,
               8'd5, 1'b1, 1'b0, '0, 1'b0);
        expect_redir("R4 nonzero form count 5", 1'b1, 1'b1, 16'h0700);
        decode(16'h0200, {K_NO, K_NO, K_NO, K_CT}, 4'b0000, {48'h0, 16'h0700}, 1'b1,
               8'd1, 1'b1, 1'b0, '0, 1'b0);
        expect_redir("R4 nonzero form count 1", 1'b1, 1'b0, 16'h0201);
        decode(16'h0200, {K_NO, K_NO, K_NO, K_CT}, 4'b0000, {48'h0, 16'h0700}, 1'b1,
               8'd0, 1'b1, 1'b0, '0, 1'b0);
        expect_redir("R4 count 0 wraps nonzero", 1'b0, 1'b0, '0);
        decode(16'h0200, {K_NO, K_NO, K_NO, K_CT}, 4'b0001, {48'h0, 16'h0700}, 1'b0,
               8'd1, 1'b1, 1'b0, '0, 1'b0);
        expect_redir("R5 zero form count 1", 1'b1, 1'b1, 16'h0700);
        decode(16'h0200, {K_NO, K_NO, K_NO, K_CT}, 4'b0001, {48'h0, 16'h0700}, 1'b1,
               8'd3, 1'b1, 1'b0, '0, 1'b0);
        expect_redir("R5 zero form count 3", 1'b1, 1'b0, 16'h0201);
    endtask

    task automatic t_counter;
        update(16'h0025, 1'b1);                       // 01 -> 10
        flag0(16'h0025, 1'b0);
        expect_redir("R7 weak nt to weak t", 1'b1, 1'b1, 16'h0900);
        update(16'h0025, 1'b1);                       // 11
        update(16'h0025, 1'b0);                       // 10
        flag0(16'h0025, 1'b0);
        expect_redir("R7 strong t to weak t", 1'b1, 1'b1, 16'h0900);
        update(16'h0025, 1'b0);                       // 01
        flag0(16'h0025, 1'b1);
        expect_redir("R7 weak t to weak nt", 1'b1, 1'b0, 16'h0026);
        for (int i = 0; i < 3; i++) update(16'h0025, 1'b0); // 00
        update(16'h0025, 1'b1);                       // 01
        flag0(16'h0025, 1'b1);
        expect_redir("R7 saturate at strong nt", 1'b1, 1'b0, 16'h0026);
        for (int i = 0; i < 4; i++) update(16'h0025, 1'b1); // 11
        update(16'h0025, 1'b0);                       // 10
        flag0(16'h0025, 1'b0);
        expect_redir("R7 saturate at strong t", 1'b1, 1'b1, 16'h0900);
    endtask

    task automatic t_index;
        flag0(16'h0225, 1'b1);
        expect_redir("R6 aliased index agrees", 1'b0, 1'b0, '0);
        decode(16'h0023, {K_NO, K_FL, K_NO, K_NO}, '0, {16'h0, 16'h0B00, 32'h0},
               1'b0, '0, 1'b1, 1'b0, '0, 1'b0);
        expect_redir("R6 index includes slot offset", 1'b1, 1'b1, 16'h0B00);
    endtask

    task automatic t_collide;
        decode(16'h0040, {K_NO, K_NO, K_NO, K_FL}, '0, {48'h0, 16'h0C00}, 1'b1, '0,
               1'b1, 1'b1, 16'h0040, 1'b1);
        expect_redir("R9 same-cycle read sees old value", 1'b1, 1'b0, 16'h0041);
        decode(16'h0040, {K_NO, K_NO, K_NO, K_FL}, '0, {48'h0, 16'h0C00}, 1'b0, '0,
               1'b1, 1'b0, '0, 1'b0);
        expect_redir("R9 update landed afterwards", 1'b1, 1'b1, 16'h0C00);
    endtask

    task automatic t_idle;
        decode(16'h0300, {K_NO, K_NO, K_NO, K_AL}, '0, {48'h0, 16'h0AB0}, 1'b0, '0,
               1'b0, 1'b0, '0, 1'b0);
        expect_redir("R10 decode not valid", 1'b0, 1'b0, '0);
        decode(16'h0300, '0, '0, {48'h0, 16'h0AB0}, 1'b0, '0, 1'b1, 1'b0, '0, 1'b0);
        expect_redir("R10 no branch in group", 1'b0, 1'b0, '0);
        @(negedge clk);
        expect_redir("R8 redirect lasts one cycle", 1'b0, 1'b0, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_uncond();
        t_first();
        t_count();
        t_counter();
        t_index();
        t_collide();
        t_idle();
        // R8: redirect pulse from a single decode clears on the next cycle
        decode(16'h0300, {K_NO, K_NO, K_NO, K_AL}, '0, {48'h0, 16'h0AB0}, 1'b0, '0,
               1'b1, 1'b0, '0, 1'b0);
        expect_redir("R8 pulse present", 1'b1, 1'b1, 16'h0AB0);
        @(posedge clk); #1;
        expect_redir("R8 pulse gone", 1'b0, 1'b0, '0);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule